// File: doc/BRIEF.md
# Gated Frequency and Period Counter

This block measures one of two already-synchronized digital inputs with a single saturating counter. In frequency mode it counts rising edges of the chosen input during a gate window of fixed length; the window length is one of four clock-cycle counts picked by a two-bit select. In period mode it counts system clock cycles from one rising edge of the low-frequency input to the next.

A one-cycle start pulse captures the mode code and the gate select, clears the result and the completion flag, and opens the measurement. The captured configuration holds until the next start, so the controlling logic may change its select lines while a measurement is running. When the measurement ends, the done flag rises and the result stays frozen until the next start. After reset the captured configuration is frequency measurement on the high-frequency input.

Top module: `gated_freq_counter`

## Requirements
- R1: After reset, `result` is 0 and `done` is 0.
- R2: A cycle with `start` high clears `result` to 0 and `done` to 0 by the next cycle, and abandons any measurement in progress in favour of a new one.
- R3: Mode code 2'b00 counts rising edges of `hf_in` (a low sample followed by a high sample) seen on the GATE clock edges that follow the start edge.
- R4: Mode code 2'b01 counts rising edges of `lf_in` in the same way, and activity on `hf_in` has no effect on the result.
- R5: Gate select 2'b00, 2'b01, 2'b10, 2'b11 chooses a window of GATE_0, GATE_1, GATE_2, GATE_3 clock cycles (defaults 4500, 18000, 36000, 144000, i.e. 1, 4, 8, 32 ms at 4.5 MHz); `done` rises on exactly the GATE-th edge after the start edge.
- R6: Mode codes 2'b10 and 2'b11 measure the number of clock cycles between the first and second rising edges of `lf_in` after start; `done` rises on the edge that samples the second rising edge, the gate select has no effect, and `hf_in` is ignored.
- R7: Once `done` is high, it stays high and `result` stays unchanged until the next start.
- R8: The result saturates at all ones instead of wrapping.
- R9: Changes on `mode` and `gate_sel` while a measurement runs have no effect on that measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hf_in | input | 1 | High-frequency measurement input, synchronized |
| lf_in | input | 1 | Low-frequency measurement input, synchronized |
| mode | input | 2 | Channel and measurement type, captured at start |
| gate_sel | input | 2 | Gate window select, captured at start |
| start | input | 1 | One-cycle pulse that begins a measurement |
| result | output | CNT_W | Count of edges or of clock cycles |
| done | output | 1 | Measurement complete |

## Verification
Square waves with half-periods of 1 to 50 cycles are applied across all four gate lengths, so an off-by-one in the window or in edge detection shows up as a count one away from the expected value, and the done flag is sampled one cycle before and on its expected edge. The unselected input toggles every cycle in each run, which separates a wrong channel select from a correct one. Period runs use waves with distinct half-periods under different gate selects to show the gate select is ignored there, and dedicated runs push both modes past the counter range, restart mid-measurement, and change the select lines while busy.

// File: rtl/gated_freq_counter.sv
module gated_freq_counter #(
  parameter int CNT_W  = 20,
  parameter int GATE_0 = 4500,
  parameter int GATE_1 = 18000,
  parameter int GATE_2 = 36000,
  parameter int GATE_3 = 144000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hf_in,
  input  logic             lf_in,
  input  logic [1:0]       mode,
  input  logic [1:0]       gate_sel,
  input  logic             start,
  output logic [CNT_W-1:0] result,
  output logic             done
);

  localparam int GMAX_A = (GATE_0 > GATE_1) ? GATE_0 : GATE_1;
  localparam int GMAX_B = (GATE_2 > GATE_3) ? GATE_2 : GATE_3;
  localparam int GMAX   = (GMAX_A > GMAX_B) ? GMAX_A : GMAX_B;
  localparam int GW     = $clog2(GMAX + 1);

  logic [1:0]       mode_q, gsel_q;
  logic             busy, armed, prev;
  logic [GW-1:0]    tick, gate_len;
  logic [CNT_W-1:0] result_q;
  logic             done_q;

  wire sel_in    = (mode_q == 2'b00) ? hf_in : lf_in;
  wire start_in  = (mode == 2'b00) ? hf_in : lf_in;
  wire rise      = sel_in & ~prev;
  wire is_period = mode_q[1];
  wire last_tick = (tick == gate_len - 1'b1);
  wire [CNT_W-1:0] inc = (&result_q) ? result_q : result_q + 1'b1;

  always_comb begin
    case (gsel_q)
      2'b00:   gate_len = GW'(GATE_0);
      2'b01:   gate_len = GW'(GATE_1);
      2'b10:   gate_len = GW'(GATE_2);
      default: gate_len = GW'(GATE_3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= 2'b00;
      gsel_q   <= 2'b00;
      busy     <= 1'b0;
      armed    <= 1'b0;
      prev     <= 1'b0;
      tick     <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else if (start) begin
      mode_q   <= mode;
      gsel_q   <= gate_sel;
      busy     <= 1'b1;
      armed    <= 1'b0;
      prev     <= start_in;
      tick     <= '0;
      result_q <= '0;
      done_q   <= 1'b0;
    end else if (busy) begin
      prev <= sel_in;
      if (is_period) begin
        if (armed) result_q <= inc;
        if (rise) begin
          armed <= 1'b1;
          if (armed) begin
            busy   <= 1'b0;
            done_q <= 1'b1;
          end
        end
      end else begin
        if (rise) result_q <= inc;
        tick <= tick + 1'b1;
        if (last_tick) begin
          busy   <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign result = result_q;
  assign done   = done_q;

  // R2
  start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (!done && result == '0));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(result)));

  // R8
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && (&result)) |=> (&result));

  // R3
  step_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (result == $past(result) || result == $past(result) + 1'b1));

  // R7
  idle_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

endmodule

// File: tb/gated_freq_counter_test.sv
module gated_freq_counter_test;
  localparam int W = 8;
  localparam int G0 = 40, G1 = 160, G2 = 320, G3 = 1280;
  localparam int NV = 9;
  // mode, gate_sel, half-period, expected result
  localparam int VEC [NV][4] = '{
    '{0, 0,  3,   7},
    '{0, 1,  5,  16},
    '{1, 2,  7,  23},
    '{1, 3, 20,  32},
    '{0, 3,  9,  71},
    '{2, 0, 10,  20},
    '{2, 2, 37,  74},
    '{3, 1, 50, 100},
    '{0, 0, 50,   0}
  };

  logic clk = 1'b0, rst_n = 1'b0, hf_in = 1'b0, lf_in = 1'b0, start = 1'b0;
  logic [1:0] mode = 2'b00, gate_sel = 2'b00;
  logic [W-1:0] result;
  logic done;
  int tests = 0, fails = 0;

  always #5 clk = ~clk;

  gated_freq_counter #(.CNT_W(W), .GATE_0(G0), .GATE_1(G1), .GATE_2(G2), .GATE_3(G3)) uut (
    .clk(clk), .rst_n(rst_n), .hf_in(hf_in), .lf_in(lf_in), .mode(mode),
    .gate_sel(gate_sel), .start(start), .result(result), .done(done));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int gate_of(input int g);
    return g == 0 ? G0 : g == 1 ? G1 : g == 2 ? G2 : G3;
  endfunction

  // Drives a square wave of half-period h on the selected channel, the other
  // channel toggling every cycle; k counts clock edges after the start edge.
  task automatic run(input int m, input int g, input int h, input int exp,
                     input int chg_at, input string tag);
    int fin = (m >= 2) ? 3 * h : gate_of(g);
    int mo = m;
    @(negedge clk);
    mode = 2'(m); gate_sel = 2'(g); start = 1'b1;
    hf_in = 1'b0; lf_in = 1'b0;
    for (int k = 1; k <= fin + 2; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (k == chg_at) begin mode = ~mode; gate_sel = 2'b00; end
      if (mo == 0) begin hf_in = ((k / h) % 2) == 1; lf_in = k[0]; end
      else begin lf_in = ((k / h) % 2) == 1; hf_in = k[0]; end
      if (k == fin) chk(done == 1'b0, {tag, " R5 done early"}, int'(done), 0);
      if (k == fin + 1) chk(done == 1'b1, {tag, " R5 done timing"}, int'(done), 1);
    end
    chk(result == W'(exp), {tag, " result"}, int'(result), exp);
  endtask

  initial begin
    #1500000;
    fails++; tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(result == '0, "R1 result after reset", int'(result), 0);
    chk(done == 1'b0, "R1 done after reset", int'(done), 0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string t;
      t = VEC[i][0] == 0 ? "R3" : VEC[i][0] == 1 ? "R4" : "R6";
      run(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], -1, t);
      repeat (20) begin
        @(negedge clk);
        hf_in = ~hf_in; lf_in = ~lf_in;
      end
      chk(done == 1'b1 && result == W'(VEC[i][3]), "R7 hold after done",
          int'(result), VEC[i][3]);
    end

    // R2: start clears result and done
    @(negedge clk);
    hf_in = 1'b0; lf_in = 1'b0; mode = 2'b00; gate_sel = 2'b11; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b0, "R2 done cleared", int'(done), 0);
    chk(result == '0, "R2 result cleared", int'(result), 0);
    repeat (100) begin
      @(negedge clk);
      hf_in = ~hf_in;
    end
    // R2: restart mid-measurement
    run(0, 0, 3, 7, -1, "R2 restart");

    // R9: select lines change while busy
    run(0, 1, 5, 16, 50, "R9 freq latched");
    run(2, 3, 10, 20, 5, "R9 period latched");

    // R8: saturation in both modes
    run(0, 3, 1, 255, -1, "R8 freq saturate");
    run(2, 0, 200, 255, -1, "R8 period saturate");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule